// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static RAM. It is 18 bits wide and split into two 9-bit byte lanes. Its depth is set by an address-width parameter, so simulation can use a small array. It sits behind a processor or cache controller. The address, strobes, chip selects, write controls and write data are all captured on the rising clock edge. Read data leaves through an output register, which makes reads pipelined: the address is sampled at one edge and the data is driven after the next edge.

An access starts when the processor strobe or the controller strobe is sampled low. The processor strobe counts only while chip select 1 is active, and a start from it is always a read. The controller strobe can start a read or a write. The start address loads a 2-bit wrapping burst counter. On later cycles the advance input steps the counter through a linear or an interleaved order. Leaving the advance input high repeats the current address. Writes cover one or both byte lanes, and a global write overrides the lane selects. The shared data bus appears as separate input, output and drive-enable ports. The drive enable models the asynchronous output enable. It also keeps the drivers off after a write and during the first clock of a read that follows a deselected state.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `dout_en` is 0 until a read has been captured and the next edge has loaded the output register.
- R2: A read whose address is sampled at edge N drives the stored word on `dout`, with `dout_en` high, after edge N+1, provided `oe_n` is low and edge N+1 is not a write.
- R3: `oe_n` acts without a clock: while it is high `dout_en` is 0, and lowering it between edges brings `dout_en` back at once if read data is held.
- R4: A controller-strobe write needs `adsc_n` low, `adsp_n` high, `cs1_n` low, `cs2` high and `cs3_n` low, plus a write request. It writes `din` in that same clock. `adv_n` is ignored on that edge, so the burst position stays at the start address.
- R5: A low `gwe_n` writes both lanes whatever `bwe_n` and `bsel_n` hold.
- R6: With `gwe_n` high and `bwe_n` low, lane i (bits 9i+8..9i) is written only if `bsel_n[i]` is low. Every other lane keeps its contents.
- R7: When `gwe_n` and `bwe_n` are both high, or `bwe_n` is low with all `bsel_n` bits high, no write takes place and the access is a read.
- R8: In the clock after an edge that performs a write, `dout_en` is 0 whatever `oe_n` is.
- R9: In the first clock after a read is started from the deselected state, `dout_en` is 0 even with `oe_n` low.
- R10: A low `adsp_n` with `cs1_n` high and `adsc_n` high starts nothing; a deselected part stays deselected.
- R11: A start with `adsp_n` low and `cs1_n` low is a read, even when `adsc_n` and the write controls are also asserted.
- R12: With `burst_lin` = 1, each edge with `adv_n` low and no start moves the low two address bits to (start + k) mod 4 for the k-th step. An edge with `adv_n` high repeats the current address.
- R13: With `burst_lin` = 0, the k-th step uses low address bits equal to start XOR k.
- R14: A start with any chip select inactive deselects the part: later non-start cycles make no access, and `dout_en` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state (the array is not cleared) |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output driver enable for the shared bus |

## Verification
The bench first fills the array with global writes, some of them with conflicting lane selects, so every later read has a known word. It then tries single reads, global and per-lane writes, and writes with no lane chosen. Together these separate the write-qualification and masking rules. Bursts start from a mid-block address in both orders, with advance and suspend cycles mixed in, and they expose any wrong step order or wrap. Further sequences cover a read right before a write, deselects through each chip select, a processor strobe with chip select 1 off, both strobes at once, and `oe_n` toggled between edges. These isolate the driver-enable masks from the data path.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     adsp_n,
  input  logic                     adsc_n,
  input  logic                     adv_n,
  input  logic                     cs1_n,
  input  logic                     cs2,
  input  logic                     cs3_n,
  input  logic                     gwe_n,
  input  logic                     bwe_n,
  input  logic [LANES-1:0]         bsel_n,
  input  logic                     burst_lin,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dout_en
);
  localparam int W     = LANES * LANE_W;
  localparam int WORDS = 1 << ADDR_W;

  logic [W-1:0]        mem [WORDS];
  logic                sel_q, rd_q, wr_q, rdv_q;
  logic [ADDR_W-1:2]   hi_q;
  logic [1:0]          base_q, ofs_q;
  logic [ADDR_W-1:0]   rd_addr_q;
  logic [W-1:0]        dout_q;

  logic                all_sel, p_go, c_go, start, wr_ask, access, is_wr, is_rd;
  logic [LANES-1:0]    lane_we;
  logic [1:0]          ofs_n, lo_n;
  logic [ADDR_W-1:0]   acc_addr;

  assign all_sel = !cs1_n && cs2 && !cs3_n;
  assign p_go    = !adsp_n && !cs1_n;
  assign c_go    = !adsc_n;
  assign start   = p_go || c_go;
  assign lane_we = {LANES{!gwe_n}} | ({LANES{!bwe_n}} & ~bsel_n);
  assign wr_ask  = |lane_we;

  assign ofs_n    = start ? 2'd0 : ofs_q + {1'b0, !adv_n};
  assign lo_n     = start ? addr[1:0] : (burst_lin ? base_q + ofs_n : base_q ^ ofs_n);
  assign acc_addr = start ? addr : {hi_q, lo_n};

  assign access = start ? all_sel : sel_q;
  assign is_wr  = access && wr_ask && !p_go;
  assign is_rd  = access && !is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rdv_q     <= 1'b0;
      hi_q      <= '0;
      base_q    <= '0;
      ofs_q     <= '0;
      rd_addr_q <= '0;
    end else begin
      if (start) begin
        sel_q  <= all_sel;
        hi_q   <= addr[ADDR_W-1:2];
        base_q <= addr[1:0];
      end
      ofs_q     <= ofs_n;
      rd_q      <= is_rd;
      wr_q      <= is_wr;
      rd_addr_q <= acc_addr;
      rdv_q     <= rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_q) dout_q <= mem[rd_addr_q];
    for (int i = 0; i < LANES; i++)
      if (rst_n && is_wr && lane_we[i])
        mem[acc_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  assign dout    = dout_q;
  assign dout_en = !oe_n && rdv_q && !wr_q;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adsp_n,
  input logic             adsc_n,
  input logic             cs1_n,
  input logic             cs2,
  input logic             cs3_n,
  input logic             gwe_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bsel_n,
  input logic             oe_n,
  input logic             dout_en
);
  logic sel_c;
  wire  on_all = !cs1_n && cs2 && !cs3_n;
  wire  ps     = !adsp_n && !cs1_n;
  wire  any_st = ps || !adsc_n;
  wire  wreq   = !gwe_n || (!bwe_n && (bsel_n != {LANES{1'b1}}));

  always_ff @(posedge clk)
    if (!rst_n) sel_c <= 1'b0;
    else if (any_st) sel_c <= on_all;

  // R3: drivers only with output enable low
  p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);

  // R8: any write edge turns the drivers off in the next clock
  p_wr_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!adsc_n && !ps && on_all && wreq) || (!any_st && sel_c && wreq)) |=> !dout_en);

  // R9: first clock of a read leaving the deselected state is masked
  p_first_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_st && on_all && !sel_c && (ps || !wreq)) |=> !dout_en);

  // R10: processor strobe with chip select 1 off starts nothing
  p_adsp_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && cs1_n && adsc_n && !sel_c) |=> !dout_en);

  // R14: a deselecting start leaves the drivers off one clock later
  p_desel_off_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (any_st && !on_all) |=> ##1 !dout_en);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;
  localparam int AW = 6, LW = 9, NL = 2, W = 18, WORDS = 64;

  logic clk = 0, rst_n;
  logic [AW-1:0] addr;
  logic adsp_n, adsc_n, adv_n, cs1_n, cs2, cs3_n, gwe_n, bwe_n, burst_lin, oe_n;
  logic [NL-1:0] bsel_n;
  logic [W-1:0] din, dout;
  logic dout_en;

  sync_burst_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .gwe_n(gwe_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .burst_lin(burst_lin), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int mmem [WORDS];
  bit m_sel, m_rdp, m_rdv, m_wr;
  int m_hi, m_base, m_ofs, m_rda, m_out;

  function automatic int dat(int k);
    return (k * 12345 + 77) & 18'h3FFFF;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit as, pg, st, acc, wr;
    int lm, a;
    if (!rst_n) begin
      m_sel = 0; m_rdp = 0; m_rdv = 0; m_wr = 0; m_ofs = 0;
      return;
    end
    as = !cs1_n && cs2 && !cs3_n;
    pg = !adsp_n && !cs1_n;
    st = pg || !adsc_n;
    lm = !gwe_n ? 3 : (!bwe_n ? (~bsel_n) & 3 : 0);
    if (m_rdp) m_out = mmem[m_rda];
    m_rdv = m_rdp;
    if (st) begin
      acc = as; m_sel = as; m_hi = addr >> 2; m_base = addr & 3; m_ofs = 0; a = addr;
      wr = acc && !pg && lm != 0;
    end else begin
      acc = m_sel;
      if (!adv_n) m_ofs = (m_ofs + 1) % 4;
      a = m_hi * 4 + (burst_lin ? (m_base + m_ofs) % 4 : (m_base ^ m_ofs));
      wr = acc && lm != 0;
    end
    if (wr)
      for (int i = 0; i < NL; i++)
        if (lm[i]) mmem[a] = (mmem[a] & ~(511 << (9*i))) | (din & (511 << (9*i)));
    m_wr = wr;
    m_rdp = acc && !wr;
    m_rda = a;
  endtask

  task automatic tick(string tag);
    bit e;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    e = !oe_n && m_rdv && !m_wr;
    check({tag, " en"}, dout_en, e);
    if (e) check({tag, " data"}, dout, m_out);
  endtask

  task automatic chk_out(string tag, int exp);
    check({tag, " drive"}, dout_en, 1);
    check({tag, " word"}, dout, exp);
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; bsel_n = 2'b11; din = '0;
    cs1_n = 0; cs2 = 1; cs3_n = 0;
  endtask

  task automatic c_start(int a);
    idle(); adsc_n = 0; addr = AW'(a);
  endtask

  task automatic p_start(int a);
    idle(); adsp_n = 0; addr = AW'(a);
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; oe_n = 0; burst_lin = 1; idle();
    for (int i = 0; i < WORDS; i++) mmem[i] = 0;
    m_out = 0;
    repeat (3) tick("R1 reset");
    check("R1 reset drive", dout_en, 0);
    rst_n = 1;
    tick("R1 after reset");

    // R5 fill with global writes, lane selects in conflict on odd words
    for (int k = 0; k < WORDS; k++) begin
      c_start(k); gwe_n = 0; din = W'(dat(k));
      if (k % 2) begin bwe_n = 0; bsel_n = 2'b01; end
      tick("R5 R8 fill");
    end

    // R2 single read
    c_start(10); tick("R2 capture");
    idle(); tick("R2 out");
    chk_out("R2 read 10", dat(10));

    // R7 bwe low but no lane chosen -> read
    c_start(11); bwe_n = 0; bsel_n = 2'b11; din = '0; tick("R7 no lane");
    idle(); tick("R7 out"); chk_out("R7 word 11 intact", dat(11));

    // R6 byte writes
    c_start(12); bwe_n = 0; bsel_n = 2'b10; din = '0; tick("R6 lane0 wr");
    c_start(12); tick("R6 rd"); idle(); tick("R6 out");
    chk_out("R6 lane0 only", dat(12) & 18'h3FE00);
    c_start(13); bwe_n = 0; bsel_n = 2'b01; din = '0; tick("R6 lane1 wr");
    c_start(13); tick("R6 rd"); idle(); tick("R6 out");
    chk_out("R6 lane1 only", dat(13) & 18'h001FF);

    // R4 adv ignored on controller-strobe write
    c_start(20); gwe_n = 0; adv_n = 0; din = 18'h2AAAA; tick("R4 wr");
    idle(); tick("R4 cont"); idle(); tick("R4 out");
    chk_out("R4 adv ignored", 18'h2AAAA);
    c_start(21); tick("R4 rd"); idle(); tick("R4 out");
    chk_out("R4 neighbour 21", dat(21));

    // R8 read then write in next clock
    c_start(5); tick("R8 rd");
    idle(); gwe_n = 0; din = 18'h12345; tick("R8 wr");
    check("R8 drivers off after write", dout_en, 0);
    idle(); tick("R8 after");

    // R12 linear burst from 33
    burst_lin = 1;
    p_start(33); tick("R12 start");
    idle(); adv_n = 0; tick("R12 s1"); chk_out("R12 first 33", dat(33));
    tick("R12 s2"); chk_out("R12 second 34", dat(34));
    tick("R12 s3"); chk_out("R12 third 35", dat(35));
    adv_n = 1; tick("R12 hold"); chk_out("R12 wrap 32", dat(32));
    tick("R12 hold2"); chk_out("R12 suspend 32", dat(32));

    // R13 interleaved burst from 38
    burst_lin = 0;
    p_start(38); tick("R13 start");
    idle(); adv_n = 0; tick("R13 s1"); chk_out("R13 first 38", dat(38));
    tick("R13 s2"); chk_out("R13 second 39", dat(39));
    tick("R13 s3"); chk_out("R13 third 36", dat(36));
    adv_n = 1; tick("R13 hold"); chk_out("R13 fourth 37", dat(37));
    burst_lin = 1;

    // R11 both strobes plus write controls -> read
    p_start(40); adsc_n = 0; gwe_n = 0; din = '0; tick("R11 start");
    idle(); tick("R11 out"); chk_out("R11 read 40", dat(40));
    tick("R11 again"); chk_out("R11 not written", dat(40));

    // R14 deselect via cs2, then R10
    c_start(41); cs2 = 0; tick("R14 desel");
    idle(); tick("R14 idle");
    check("R14 drivers off", dout_en, 0);
    p_start(41); cs1_n = 1; tick("R10 ignored");
    idle(); tick("R10 idle");
    check("R10 no access", dout_en, 0);

    // R9 read from deselected state
    c_start(42); tick("R9 first");
    check("R9 masked first clock", dout_en, 0);
    idle(); tick("R9 out"); chk_out("R9 data 42", dat(42));

    // R3 asynchronous output enable
    #0.5 oe_n = 1; #0.5;
    check("R3 oe high", dout_en, 0);
    oe_n = 0; #0.5;
    check("R3 oe low", dout_en, 1);
    tick("R3 cont");

    // R14 deselect via cs3
    c_start(43); cs3_n = 1; tick("R14 cs3 desel");
    idle(); tick("R14 cs3 idle");
    check("R14 cs3 off", dout_en, 0);
    idle(); tick("R14 stay");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule